// File: doc/BRIEF.md
# Fine-Grained Configurable Logic Tile

This block is one tile of a fine-grained programmable fabric. Its logic element is a two-input multiplexer used as a universal logic module: the data inputs X0 and X1 and the select input SEL are each chosen from one of the four directional neighbour inputs. The two data inputs can be inverted on the way in. A configuration bit chooses whether the tile's logic result is the multiplexer output straight through or a copy of it held in a flip-flop.

Each of the four directional outputs has its own four-way router. It forwards either the tile's logic result or one of the other three neighbour inputs. A signal can therefore cross a tile untouched and reach cells that are not adjacent. All behaviour is set by a 17-bit configuration word, which a loader outside this block keeps stable.

Top module: `fgc_tile`

## Requirements
- R1: The combinational function value is F = (~SEL & X0) | (SEL & X1). With SEL and X0 taken from N and X1 from E, the tile computes N AND E. With SEL from N, X0 from E and X1 from the inverted E, it computes N XOR E.
- R2: The three source fields pick a neighbour with the code 00=N, 01=E, 10=S, 11=W. X0 uses cfg[11:10], X1 uses cfg[13:12] and SEL uses cfg[15:14]. In `in_dir` and `out_dir`, bit 0 is N, bit 1 is E, bit 2 is S and bit 3 is W.
- R3: When cfg[8] is 1, X0 is the inverse of the picked neighbour. When cfg[9] is 1, X1 is the inverse of the picked neighbour. When either bit is 0, the matching input passes true.
- R4: When cfg[16] is 0, the logic result is F as a combinational value. When cfg[16] is 1, the logic result is the flip-flop output, which changes only on a rising clock edge.
- R5: While `rst` is high at a rising edge, the flip-flop clears to 0. The clear is synchronous, so the output does not change before that edge.
- R6: The flip-flop loads F on every rising edge whether cfg[16] is 0 or 1. Switching to registered mode therefore shows at once the F value captured at the last edge.
- R7: Each output router has its own field: N in cfg[1:0], E in cfg[3:2], S in cfg[5:4] and W in cfg[7:6]. Code 00 drives the tile's logic result.
- R8: Router codes 01, 10 and 11 forward the other three neighbour inputs in N, E, S, W order, skipping the output's own direction. For example, the N output's code 01 forwards E, and the W output's code 11 forwards S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result flip-flop |
| rst | input | 1 | Synchronous active-high clear of the flip-flop |
| cfg | input | 17 | Configuration word |
| in_dir | input | 4 | Neighbour inputs {W,S,E,N} |
| out_dir | output | 4 | Neighbour outputs {W,S,E,N} |

## Verification
Every cycle, the assertions check that the flip-flop follows F one edge later, that it is zero after a reset edge, that router code 00 carries the logic result, that a chosen pass-through forwards its neighbour, and that a low select with a true X0 passes X0 straight to the result. Only the bench scenarios show the complete function table. These cover AND, XOR, input inversion and every router's skip order, as well as the timing of the synchronous clear, the hold between edges in registered mode, and the capture that goes on while the tile is in combinational mode.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
  localparam int NDIR  = 4;
  localparam int SW    = $clog2(NDIR);
  localparam int CFG_W = NDIR*SW + 2 + 3*SW + 1;

  typedef logic [SW-1:0] code_t;

  // Field order from MSB: mode, sel src, x1 src, x0 src, x1 inv, x0 inv, routes
  typedef struct packed {
    logic                  mode;
    code_t                 src_s;
    code_t                 src1;
    code_t                 src0;
    logic                  inv1;
    logic                  inv0;
    code_t [NDIR-1:0]      route;
  } cfg_t;
endpackage

// File: rtl/fgc_pick.sv
`timescale 1ns/1ps
module fgc_pick #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  din,
  input  logic [SW-1:0] code,
  input  logic          inv,
  output logic          y
);
  always_comb y = din[code] ^ inv;
endmodule

// File: rtl/fgc_core.sv
`timescale 1ns/1ps
module fgc_core (
  input  logic clk,
  input  logic rst,
  input  logic x0,
  input  logic x1,
  input  logic s,
  input  logic mode,
  output logic f,
  output logic res
);
  logic q;

  always_comb f = s ? x1 : x0;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= f;
  end

  always_comb res = mode ? q : f;

  // R6: flip-flop follows F one edge later, regardless of mode
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q == $past(f));
  // R5: first cycle after a reset edge shows a cleared register
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == 1'b0);
endmodule

// File: rtl/fgc_route.sv
`timescale 1ns/1ps
module fgc_route #(
  parameter int N   = 4,
  parameter int SW  = $clog2(N),
  parameter int OWN = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  din,
  input  logic          logic_in,
  input  logic [SW-1:0] code,
  output logic          y
);
  logic [N-1:0] cand;

  assign cand[0] = logic_in;
  for (genvar k = 1; k < N; k++) begin : g_cand
    if (k - 1 < OWN) begin : g_below
      assign cand[k] = din[k-1];
    end else begin : g_above
      assign cand[k] = din[k];
    end
  end

  always_comb y = cand[code];

  // R7: code 00 carries the tile's logic result
  a_r7_logic_out: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |-> y == logic_in);
endmodule

// File: rtl/fgc_tile.sv
`timescale 1ns/1ps
module fgc_tile
  import fgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NDIR-1:0]  in_dir,
  output logic [NDIR-1:0]  out_dir
);
  cfg_t c;
  logic x0, x1, s, f, res;

  assign c = cfg_t'(cfg);

  fgc_pick #(.N(NDIR), .SW(SW)) u_pick_x0 (.din(in_dir), .code(c.src0),  .inv(c.inv0), .y(x0));
  fgc_pick #(.N(NDIR), .SW(SW)) u_pick_x1 (.din(in_dir), .code(c.src1),  .inv(c.inv1), .y(x1));
  fgc_pick #(.N(NDIR), .SW(SW)) u_pick_s  (.din(in_dir), .code(c.src_s), .inv(1'b0),   .y(s));

  fgc_core u_core (
    .clk(clk), .rst(rst), .x0(x0), .x1(x1), .s(s),
    .mode(c.mode), .f(f), .res(res)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_route
    fgc_route #(.N(NDIR), .SW(SW), .OWN(d)) u_route (
      .clk(clk), .rst(rst), .din(in_dir), .logic_in(res),
      .code(c.route[d]), .y(out_dir[d])
    );
  end

  // R1: low select with true X0 passes the X0 neighbour to the result
  a_r1_sel_low: assert property (@(posedge clk) disable iff (rst)
    (!c.mode && !in_dir[c.src_s] && !c.inv0) |-> res == in_dir[c.src0]);
  // R8: N output code 10 forwards the S input
  a_r8_pass_ns: assert property (@(posedge clk) disable iff (rst)
    (c.route[0] == 2'd2) |-> out_dir[0] == in_dir[2]);
endmodule

// File: tb/fgc_tile_test.sv
`timescale 1ns/1ps
module fgc_tile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] cfg = '0;
  logic [3:0]  in_dir = '0;
  logic [3:0]  out_dir;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fgc_tile uut (.clk(clk), .rst(rst), .cfg(cfg), .in_dir(in_dir), .out_dir(out_dir));

  // routes n,e,s,w; inv0, inv1; src x0, x1, sel; mode
  function automatic logic [16:0] mk(int rn, int re, int rs, int rw, int i0, int i1,
                                     int s0, int s1, int ss, int md);
    logic [1:0] a, b, cc, d, e0, e1, es;
    a = rn[1:0]; b = re[1:0]; cc = rs[1:0]; d = rw[1:0];
    e0 = s0[1:0]; e1 = s1[1:0]; es = ss[1:0];
    return {md[0], es, e1, e0, i1[0], i0[0], d, cc, b, a};
  endfunction

  // {cfg, in_dir, expected out_dir}
  localparam logic [24:0] VEC [9] = '{
    {mk(0,0,0,0, 0,0, 0,1,0, 0), 4'b0011, 4'b1111},  // AND 1,1
    {mk(0,0,0,0, 0,0, 0,1,0, 0), 4'b0001, 4'b0000},  // AND 1,0
    {mk(0,0,0,0, 0,0, 0,1,0, 0), 4'b0010, 4'b0000},  // AND 0,1
    {mk(0,0,0,0, 0,1, 1,1,0, 0), 4'b0011, 4'b0000},  // XOR 1,1
    {mk(0,0,0,0, 0,1, 1,1,0, 0), 4'b0010, 4'b1111},  // XOR 0,1
    {mk(0,0,0,0, 0,1, 1,1,0, 0), 4'b0001, 4'b1111},  // XOR 1,0
    {mk(1,1,3,3, 0,0, 0,0,0, 0), 4'b0110, 4'b1001},  // pass-through set A
    {mk(2,2,2,2, 0,0, 0,0,0, 0), 4'b0100, 4'b0011},  // pass-through set B
    {mk(0,3,1,0, 1,0, 2,0,3, 0), 4'b0000, 4'b1001}   // inverted X0, sel from W
  };

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string vtag(int i);
    if (i < 6)      return "R1 R2 R7 table";
    else if (i < 8) return "R8 R2 table";
    else            return "R3 R2 table";
  endfunction

  initial begin
    // reset state (R5): registered AND with inputs true, output still cleared
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 1);
    in_dir = 4'b0011;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk("R5 reset state", out_dir, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cfg = VEC[i][24:8];
      in_dir = VEC[i][7:4];
      #1;
      chk(vtag(i), out_dir, VEC[i][3:0]);
    end

    // R4 registered mode: update only at edges
    @(negedge clk);
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 1);
    in_dir = 4'b0011;
    @(posedge clk); #1;
    chk("R4 reg load", out_dir, 4'b1111);
    @(negedge clk);
    in_dir = 4'b0001; #1;
    chk("R4 reg hold", out_dir, 4'b1111);
    @(posedge clk); #1;
    chk("R4 reg next edge", out_dir, 4'b0000);
    @(negedge clk);
    in_dir = 4'b0011;
    @(posedge clk); #1;
    chk("R4 reg reload", out_dir, 4'b1111);

    // R5 synchronous clear
    @(negedge clk);
    rst = 1'b1; #1;
    chk("R5 no async clear", out_dir, 4'b1111);
    @(posedge clk); #1;
    chk("R5 clear at edge", out_dir, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    // R6 capture while combinational
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 0);
    in_dir = 4'b0011; #1;
    chk("R4 comb mode", out_dir, 4'b1111);
    @(posedge clk);
    @(negedge clk);
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 1);
    in_dir = 4'b0001; #1;
    chk("R6 captured one", out_dir, 4'b1111);
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 0); #1;
    chk("R4 comb after switch", out_dir, 4'b0000);
    @(posedge clk);
    @(negedge clk);
    in_dir = 4'b0011;
    cfg = mk(0,0,0,0, 0,0, 0,1,0, 1); #1;
    chk("R6 captured zero", out_dir, 4'b0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule